// File: doc/BRIEF.md
# Peripheral Bring-Up Sequencer

This block owns the clock-enable and reset lines of one peripheral and applies them in a safe order. An enable request first looks at the peripheral's present state, taken from two status inputs. If the clock already runs and reset is already released, the request finishes at once and nothing changes. Otherwise, if the peripheral has a reset line, the block puts it in reset and waits a short settle time. It then turns the clock on and waits a much longer stabilisation time before it releases reset. If the peripheral has no reset line, the block only turns the clock on.

A disable request stops the clock and leaves reset as it is. Both wait times are parameters counted in system clock cycles. While a request is in progress, busy is high and further requests are dropped. A one-cycle done pulse marks the end of every accepted request. Arbitration between several peripherals is left to the surrounding logic.

Top module: `periph_bringup_seq`

## Requirements
- R1: After reset (rst_ni low, asynchronous) clk_en_o=0, prst_o=1, busy_o=0 and done_o=0, and this also holds when reset strikes during a sequence.
- R2: An enable request accepted while clk_on_i=1 and rst_on_i=0 changes neither clk_en_o nor prst_o, and done_o is high in the cycle after the accepting edge.
- R3: The peripheral counts as running only when clk_on_i=1 and rst_on_i=0; any other combination makes an enable request run its full path.
- R4: On the full path (has_rst_i=1), prst_o is 1 from the accepting edge on, and clk_en_o becomes 1 exactly SETTLE_CYC cycles after the accepting edge.
- R5: On the full path, prst_o returns to 0 exactly HOLD_CYC cycles after clk_en_o became 1, and never while clk_en_o is 0.
- R6: With has_rst_i=0, an enable request that is not skipped sets clk_en_o to 1 at the accepting edge and leaves prst_o unchanged.
- R7: A disable request clears clk_en_o at the accepting edge and leaves prst_o unchanged.
- R8: busy_o is high from the accepting edge until the cycle in which done_o is high, inclusive, and requests seen while busy_o is high have no effect.
- R9: done_o is high for exactly one cycle per accepted request, on the last busy cycle.
- R10: When enable and disable are requested in the same cycle, the enable is carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_req_i | input | 1 | Enable request, sampled while idle |
| dis_req_i | input | 1 | Disable request, sampled while idle |
| has_rst_i | input | 1 | Peripheral has a reset line |
| clk_on_i | input | 1 | Present clock state of the peripheral (1 = running) |
| rst_on_i | input | 1 | Present reset state of the peripheral (1 = held in reset) |
| clk_en_o | output | 1 | Clock enable to the peripheral |
| prst_o | output | 1 | Reset to the peripheral, active high |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps enable requests over all eight combinations of has_rst_i, clk_on_i and rst_on_i. This separates the skip case, the clock-only case and the full sequence, and it shows that a clock running under reset is not taken as up. Every cycle of each request is compared with an arithmetic trajectory built from the two wait lengths, so an off-by-one in either wait shows up. Disable, simultaneous enable and disable, requests injected while busy, and a reset in mid-sequence each test one rule the sweep cannot reach.

// File: rtl/bringup_pkg.sv
package bringup_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HOLD   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_FIN    = 2'd3
  } seq_st_e;
endpackage

// File: rtl/bringup_wait_cnt.sv
module bringup_wait_cnt #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] limit_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q;

  assign hit_o = run_i && (cnt_q == limit_i - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (hit_o)     cnt_q <= '0;
    else                cnt_q <= cnt_q + CW'(1);
  end

  // R4 R5
  cnt_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < limit_i));
endmodule

// File: rtl/bringup_live_det.sv
module bringup_live_det (
  input  logic clk_on_i,
  input  logic rst_on_i,
  output logic live_o
);
  // running means clock on and reset released
  assign live_o = clk_on_i && !rst_on_i;
endmodule

// File: rtl/periph_bringup_seq.sv
module periph_bringup_seq
  import bringup_pkg::*;
#(
  parameter int SETTLE_CYC = 20000,
  parameter int HOLD_CYC   = 2000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_req_i,
  input  logic dis_req_i,
  input  logic has_rst_i,
  input  logic clk_on_i,
  input  logic rst_on_i,
  output logic clk_en_o,
  output logic prst_o,
  output logic busy_o,
  output logic done_o
);
  localparam int MAXC = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
  localparam int CW   = $clog2(MAXC + 1) + 1;
  localparam logic [CW-1:0] SETTLE_L = CW'(SETTLE_CYC);
  localparam logic [CW-1:0] HOLD_L   = CW'(HOLD_CYC);

  seq_st_e       st_q;
  logic          live;
  logic          wait_run;
  logic          wait_hit;
  logic [CW-1:0] wait_lim;

  bringup_live_det u_live (
    .clk_on_i (clk_on_i),
    .rst_on_i (rst_on_i),
    .live_o   (live)
  );

  assign wait_run = (st_q == ST_HOLD) || (st_q == ST_SETTLE);
  assign wait_lim = (st_q == ST_HOLD) ? SETTLE_L : HOLD_L;

  bringup_wait_cnt #(.CW(CW)) u_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (wait_run),
    .limit_i (wait_lim),
    .hit_o   (wait_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      clk_en_o <= 1'b0;
      prst_o   <= 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (en_req_i) begin
            if (live) begin
              st_q <= ST_FIN;
            end else if (!has_rst_i) begin
              clk_en_o <= 1'b1;
              st_q     <= ST_FIN;
            end else begin
              prst_o <= 1'b1;
              st_q   <= ST_HOLD;
            end
          end else if (dis_req_i) begin
            clk_en_o <= 1'b0;
            st_q     <= ST_FIN;
          end
        end
        ST_HOLD: begin
          if (wait_hit) begin
            clk_en_o <= 1'b1;
            st_q     <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (wait_hit) begin
            prst_o <= 1'b0;
            st_q   <= ST_FIN;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = (st_q == ST_FIN);

  // R5
  rst_release_with_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prst_o) |-> clk_en_o);
  // R4
  rst_rise_in_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prst_o) |-> busy_o);
  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  done_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  // R7
  clk_off_keeps_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_en_o) |-> $stable(prst_o));
endmodule

// File: tb/periph_bringup_seq_bench.sv
module periph_bringup_seq_bench;
  localparam int S = 5;
  localparam int L = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_req = 1'b0, dis_req = 1'b0, has_rst = 1'b0, clk_on = 1'b0, rst_on = 1'b0;
  logic clk_en, prst, busy, done;
  int   checks = 0, errors = 0, cycles = 0;
  bit   m_clk, m_rst;

  always #2.5 clk = ~clk;

  periph_bringup_seq #(.SETTLE_CYC(S), .HOLD_CYC(L)) u_periph_bringup_seq (
    .clk_i(clk), .rst_ni(rst_ni), .en_req_i(en_req), .dis_req_i(dis_req),
    .has_rst_i(has_rst), .clk_on_i(clk_on), .rst_on_i(rst_on),
    .clk_en_o(clk_en), .prst_o(prst), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic run_req(input bit en, input bit dis, input bit has, input bit con,
                         input bit ron, input bit inj);
    bit skip, full, nores, disp;
    int fin;
    bit pc, pr, ec, er;
    string rq_c, rq_r;
    @(negedge clk);
    en_req = en; dis_req = dis; has_rst = has; clk_on = con; rst_on = ron;
    skip  = en && con && !ron;
    full  = en && has && !skip;
    nores = en && !has && !skip;
    disp  = !en && dis;
    fin   = full ? S + L : 0;
    pc = m_clk; pr = m_rst;
    rq_c = full ? ((con && ron) ? "R3" : "R4") : skip ? "R2" : nores ? ((dis) ? "R10" : "R6") : "R7";
    rq_r = full ? "R5" : skip ? "R2" : nores ? "R6" : "R7";
    @(posedge clk); #1;
    en_req = 1'b0; dis_req = 1'b0;
    for (int k = 0; k <= fin + 1; k++) begin
      if (k > 0) begin @(posedge clk); #1; end
      if (inj && k == 2) begin en_req = 1'b1; dis_req = 1'b1; end
      if (inj && k == 4) begin en_req = 1'b0; dis_req = 1'b0; end
      if (full)       begin ec = (k >= S) ? 1'b1 : pc; er = (k < S + L); end
      else if (skip)  begin ec = pc;   er = pr; end
      else if (nores) begin ec = 1'b1; er = pr; end
      else            begin ec = 1'b0; er = pr; end
      chk(inj ? "R8" : rq_c, "clk_en", clk_en, ec);
      chk(inj ? "R8" : rq_r, "prst", prst, er);
      chk("R8", "busy", busy, k <= fin);
      chk("R9", "done", done, k == fin);
    end
    m_clk = ec; m_rst = er;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    chk("R1", "clk_en", clk_en, 1'b0);
    chk("R1", "prst", prst, 1'b1);
    chk("R1", "busy", busy, 1'b0);
    chk("R1", "done", done, 1'b0);
    @(negedge clk); rst_ni = 1'b1;
    m_clk = 1'b0; m_rst = 1'b1;

    for (int h = 0; h < 2; h++)
      for (int c = 0; c < 2; c++)
        for (int r = 0; r < 2; r++) begin
          run_req(1'b1, 1'b0, h[0], c[0], r[0], 1'b0);
          run_req(1'b0, 1'b1, h[0], c[0], r[0], 1'b0);
        end

    // R10 both at once, enable wins
    run_req(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // R7 disable after clock-only enable
    run_req(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // R8 requests during a full sequence are ignored
    run_req(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);

    // R1 reset in mid-sequence
    @(negedge clk);
    en_req = 1'b1; has_rst = 1'b1; clk_on = 1'b1; rst_on = 1'b1;
    @(negedge clk); en_req = 1'b0;
    repeat (S + 2) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R1", "clk_en", clk_en, 1'b0);
    chk("R1", "prst", prst, 1'b1);
    chk("R1", "busy", busy, 1'b0);
    chk("R1", "done", done, 1'b0);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    chk("R1", "idle after release", busy, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule